// File: doc/BRIEF.md
# Packet-Gated Stream FIFO

This block buffers a continuous stream of 32-bit words and hands them to a downstream sink only in complete, fixed-length packets. It sits between a capture framer and a streaming network sink. The writer side produces words steadily. The reader side drains faster than the writer. An ordinary FIFO would signal data whenever it held anything, so a fast reader would empty it partway through a packet and the packet would come out short.

The FIFO holds its output valid low until the stored level reaches one full packet (336 words by default, which is 48 frames of seven words). It then presents the whole packet without a gap and flags the final word with `out_last`. Its storage holds several packets. One packet can fill while another drains, and short stalls of the sink are absorbed. When the storage is full, the input ready drops. A write offered while the FIFO is full is discarded and sets a sticky overflow flag.

Top module: `pkt_gate_fifo`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `in_ready` is 1 and `ovf_seen` is 0.
- R2: While fewer than PKT_WORDS words are stored and no packet is in progress, `out_valid` stays 0.
- R3: When the stored level reaches PKT_WORDS, `out_valid` rises on the second rising edge after the write that completed the packet.
- R4: Once `out_valid` has risen, it stays 1 on every cycle until the handshake of the packet's final word.
- R5: `out_last` is 1 on exactly the PKT_WORDS-th word of each packet (counting from 1) and 0 on every other presented word.
- R6: Words leave in the order in which they were accepted, and their values are unchanged.
- R7: `in_ready` is 0 while DEPTH words are stored. A word offered at that time is not stored and never appears at the output.
- R8: `ovf_seen` becomes 1 on the edge after a cycle with `in_valid`=1 and `in_ready`=0, and it then stays 1 until reset.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Writer offers a word |
| in_ready | output | 1 | FIFO can accept a word (not full) |
| in_data | input | DATA_W | Word offered by the writer |
| out_valid | output | 1 | A packet word is presented |
| out_ready | input | 1 | Sink takes the presented word |
| out_data | output | DATA_W | Presented word |
| out_last | output | 1 | Presented word is the last of its packet |
| ovf_seen | output | 1 | Sticky: a write was offered while full |

## Verification
If the level counter drifts, it shows up at the ports. Either a packet starts before 336 words have been accepted, or `out_valid` stays low after enough words have gone in. Both show within a few cycles of the threshold crossing. A wrong beat counter misplaces `out_last` within the first packet. It can also end a packet early, so the next packet starts too soon, or leave `out_valid` stuck high. A pointer that wraps wrongly shows as a mismatch in data order, which appears once the DEPTH-th word has gone through.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

   typedef enum logic {
      GATE_WAIT   = 1'b0,
      GATE_STREAM = 1'b1
   } gate_state_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pgf_store.sv
module pgf_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 1024,
   localparam int unsigned AW    = pgf_pkg::idx_w(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pgf_ptrs.sv
module pgf_ptrs #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW   = pgf_pkg::idx_w(DEPTH),
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [LW-1:0] level,
   output logic          full
);

   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [AW-1:0] wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
         level <= level + LW'(wr_en) - LW'(rd_en);
      end
   end

   assign full = (level == LW'(DEPTH));

endmodule

// File: rtl/pgf_gate.sv
module pgf_gate #(
   parameter int unsigned PKT_WORDS = 336,
   parameter int unsigned LW        = 11,
   localparam int unsigned BW       = pgf_pkg::idx_w(PKT_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic          rd_fire,
   output logic          valid,
   output logic          last
);

   import pgf_pkg::*;

   gate_state_e   state_q;
   logic [BW-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GATE_WAIT;
         beat_q  <= '0;
      end else begin
         unique case (state_q)
            GATE_WAIT: begin
               if (level >= LW'(PKT_WORDS)) begin
                  state_q <= GATE_STREAM;
                  beat_q  <= '0;
               end
            end
            GATE_STREAM: begin
               if (rd_fire) begin
                  if (last) state_q <= GATE_WAIT;
                  else      beat_q  <= beat_q + BW'(1);
               end
            end
            default: state_q <= GATE_WAIT;
         endcase
      end
   end

   assign valid = (state_q == GATE_STREAM);
   assign last  = valid && (beat_q == BW'(PKT_WORDS - 1));

endmodule

// File: rtl/pkt_gate_fifo.sv
module pkt_gate_fifo #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned PKT_WORDS = 336,
   parameter int unsigned DEPTH     = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              ovf_seen
);

   localparam int unsigned AW = pgf_pkg::idx_w(DEPTH);
   localparam int unsigned LW = $clog2(DEPTH + 1);

   initial begin
      assert (DATA_W >= 1) else $fatal(1, "DATA_W must be at least 1");
      assert (PKT_WORDS >= 2) else $fatal(1, "PKT_WORDS must be at least 2");
      assert (DEPTH >= 2 * PKT_WORDS) else $fatal(1, "DEPTH must hold two packets");
   end

   logic          wr_en, rd_en, full;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] level;

   assign in_ready = !full;
   assign wr_en    = in_valid && !full;
   assign rd_en    = out_valid && out_ready;

   pgf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_ptr),
      .wr_data (in_data),
      .rd_addr (rd_ptr),
      .rd_data (out_data)
   );

   pgf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .level  (level),
      .full   (full)
   );

   pgf_gate #(.PKT_WORDS(PKT_WORDS), .LW(LW)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (level),
      .rd_fire (rd_en),
      .valid   (out_valid),
      .last    (out_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 ovf_seen <= 1'b0;
      else if (in_valid && full)  ovf_seen <= 1'b1;
   end

endmodule

// File: rtl/pkt_gate_fifo_chk.sv
module pkt_gate_fifo_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned PKT_WORDS = 336,
   parameter int unsigned DEPTH     = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              ovf_seen
);

   localparam int unsigned LW = $clog2(DEPTH + 1);
   localparam int unsigned BW = pgf_pkg::idx_w(PKT_WORDS);

   logic [LW-1:0] occ;
   logic [BW-1:0] beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ  <= '0;
         beat <= '0;
      end else begin
         occ <= occ + LW'(in_valid && in_ready) - LW'(out_valid && out_ready);
         if (out_valid && out_ready)
            beat <= (beat == BW'(PKT_WORDS - 1)) ? '0 : beat + BW'(1);
      end
   end

   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (occ >= LW'(PKT_WORDS)));

   assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(out_ready && out_last)) |=> out_valid);

   assert_last_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_last == (beat == BW'(PKT_WORDS - 1))));

   assert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == LW'(DEPTH)) |-> !in_ready);

   assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> ovf_seen);

   assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_seen |=> ovf_seen);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last)));

endmodule

bind pkt_gate_fifo pkt_gate_fifo_chk #(
   .DATA_W(DATA_W), .PKT_WORDS(PKT_WORDS), .DEPTH(DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_last(out_last), .ovf_seen(ovf_seen)
);

// File: tb/sim_pkt_gate_fifo.sv
`timescale 1ns/1ps
module sim_pkt_gate_fifo;

   localparam int PKT   = 336;
   localparam int DEPTH = 1024;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        in_valid = 0;
   logic [31:0] in_data = '0;
   logic        out_ready = 0;
   logic        in_ready, out_valid, out_last, ovf_seen;
   logic [31:0] out_data;

   int checks = 0;
   int fails  = 0;
   int rmode  = 1;          // 0 stalled, 1 always ready, 2 patterned
   logic [31:0] expq [$];
   logic [31:0] seed = 32'h1000;

   always #10 clk = ~clk;   // 50 MHz

   pkt_gate_fifo u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .ovf_seen(ovf_seen)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: offers one word, records it as expected only if accepted
   task automatic wr(input logic [31:0] d);
      bit acc;
      @(negedge clk);
      in_valid = 1;
      in_data  = d;
      acc      = in_ready;
      @(posedge clk);
      if (acc) expq.push_back(d);
   endtask

   task automatic wr_n(input int n, input bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 7 == 6)) begin
            @(negedge clk);
            in_valid = 0;
         end
         wr(seed);
         seed = seed + 32'd1;
      end
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain_to(input int left);
      while (expq.size() > left) @(negedge clk);
   endtask

   // monitor: compares presented words against the scoreboard queue
   initial begin
      int   beat = 0;
      int   cyc = 0;
      bit   in_pkt = 0;
      bit   stall_prev = 0;
      logic [31:0] pd = '0;
      logic        pl = 0;
      logic [31:0] e;
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst_n) begin
            beat = 0; in_pkt = 0; stall_prev = 0;
            continue;
         end
         case (rmode)
            0: out_ready = 0;
            1: out_ready = 1;
            default: out_ready = ((cyc % 5) != 0) && ((cyc % 11) != 3);
         endcase
         if (stall_prev)
            chk(out_data == pd && out_last == pl, "R9", "held word", out_data, pd);
         if (in_pkt)
            chk(out_valid, "R4", "valid within packet", 32'(out_valid), 32'd1);
         if (out_valid) in_pkt = 1;
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               chk(0, "R6", "word with empty scoreboard", out_data, 32'hx);
            end else begin
               e = expq.pop_front();
               chk(out_data == e, "R6", "data order", out_data, e);
            end
            chk(out_last == (beat == PKT - 1), "R5", "last flag",
                32'(out_last), 32'(beat == PKT - 1));
            if (beat == PKT - 1) begin
               beat = 0;
               in_pkt = 0;
            end else begin
               beat++;
            end
         end
         stall_prev = out_valid && !out_ready;
         pd = out_data;
         pl = out_last;
      end
   end

   task automatic run_tests();
      // R1: reset state
      rmode = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 0, "R1", "out_valid after reset", 32'(out_valid), 0);
      chk(in_ready == 1,  "R1", "in_ready after reset", 32'(in_ready), 1);
      chk(ovf_seen == 0,  "R1", "ovf_seen after reset", 32'(ovf_seen), 0);
      rst_n = 1;
      idle(2);

      // R2 / R3: threshold gating
      wr_n(PKT - 1, 0);
      idle(20);
      chk(out_valid == 0, "R2", "no packet below threshold", 32'(out_valid), 0);
      wr(seed); seed++;
      @(negedge clk);
      in_valid = 0;
      chk(out_valid == 0, "R3", "one edge after final write", 32'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1, "R3", "two edges after final write", 32'(out_valid), 1);
      drain_to(0);
      idle(5);
      chk(out_valid == 0, "R2", "idle after packet", 32'(out_valid), 0);

      // R4 / R5 / R6 / R9 under a stalling sink and a gappy writer
      rmode = 2;
      wr_n(2 * PKT, 1);
      drain_to(0);
      idle(5);
      chk(expq.size() == 0, "R6", "all words delivered", expq.size(), 0);

      // R7 / R8: fill completely with the sink stopped
      rmode = 0;
      wr_n(DEPTH, 0);
      chk(in_ready == 0, "R7", "in_ready when full", 32'(in_ready), 0);
      chk(ovf_seen == 0, "R8", "no overflow yet", 32'(ovf_seen), 0);
      wr(32'hDEAD_BEEF);          // offered while full: must be dropped
      @(negedge clk);
      in_valid = 0;
      chk(ovf_seen == 1, "R8", "overflow flagged", 32'(ovf_seen), 1);
      chk(expq.size() == DEPTH, "R7", "dropped word not queued", expq.size(), DEPTH);
      rmode = 1;
      drain_to(DEPTH - 3 * PKT);
      idle(20);
      chk(out_valid == 0, "R2", "remainder below threshold", 32'(out_valid), 0);
      chk(expq.size() == DEPTH - 3 * PKT, "R2", "remainder held",
          expq.size(), DEPTH - 3 * PKT);
      chk(ovf_seen == 1, "R8", "overflow sticky", 32'(ovf_seen), 1);
      chk(in_ready == 1, "R7", "ready after drain", 32'(in_ready), 1);
      wr_n(PKT - (DEPTH - 3 * PKT), 0);
      drain_to(0);
      idle(5);
      chk(out_valid == 0, "R2", "idle at end", 32'(out_valid), 0);
      chk(expq.size() == 0, "R7", "no stray word after overflow", expq.size(), 0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule